// File: doc/BRIEF.md
# DDR Mode Register Command Decoder

This block watches the load-mode-register commands that a DDR memory controller issues. It sorts each write to the base mode register into one of three classes: normal operation, DLL reset, or a reserved or test combination. The class depends on the upper row-address bits, from A7 up to the top bit of the configured density. Normal and DLL-reset writes latch the low operating field A0–A6. Reserved writes are refused and raise a one-cycle error. Writes to the extended mode register update the DLL enable state and the output drive strength. The block does not interpret the A0–A6 subfields.

The block also checks one ordering rule. After a DLL-reset load, the next load command must select normal operation. If any other load command comes first, a warning is raised. The warning holds until a normal-mode load clears it. Every command is accepted in the cycle it is presented, so the command pins carry no back-pressure. All outputs are registered and change on the clock edge that samples the command.

Top module: `mode_cmd_decoder`

## Requirements
- R1: After reset the operating field is zero, DLL-enabled is 1, drive-reduced is 0, and the DLL-reset pulse, reserved error and sequence warning are all 0.
- R2: A load to bank 0 with address bits A7 through A[ADDR_W-1] all zero latches A0–A6 into the operating field on that edge and raises neither pulse nor error.
- R3: A load to bank 0 with A8 = 1 and every other bit from A7 through A[ADDR_W-1] zero latches A0–A6 and raises the DLL-reset pulse for exactly the following cycle.
- R4: A load to bank 0 with any other upper-bit combination raises the reserved error for exactly the following cycle and leaves the operating field unchanged.
- R5: A load to bank 1 sets DLL-enabled to the inverse of A0 (A0 = 1 disables the DLL) and sets drive-reduced to A1. The operating field is unchanged and no error is raised.
- R6: Loads to banks 2 and 3 change neither the operating field nor the extended state, and raise neither pulse nor error.
- R7: After a DLL-reset load, the warning is set by the first later load that is not a normal-mode load. This holds for any bank, and for a reserved or repeated DLL-reset load.
- R8: A normal-mode load clears the warning and ends the pending DLL-reset condition. Without a pending DLL reset, loads never set the warning.
- R9: A cycle with no load leaves every latched value unchanged and drives the pulse and error low.
- R10: The top upper bit checked is A[ADDR_W-1]. Setting it alone makes a bank-0 load reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | A load-mode-register command is present this cycle |
| cmd_bank | input | BANK_W | Bank select of the command |
| cmd_addr | input | ADDR_W | Row address of the command |
| op_field | output | 7 | Latched A0–A6 of the last accepted base write |
| dll_enabled | output | 1 | DLL enable state from the extended register |
| drive_reduced | output | 1 | Output drive strength state from the extended register |
| dll_rst_pulse | output | 1 | One-cycle pulse after a DLL-reset load |
| rsvd_err | output | 1 | One-cycle flag after a refused reserved load |
| seq_warn | output | 1 | Sticky ordering warning |

## Verification
The bench builds the decoder with ADDR_W = 10, so the upper field is three bits (A7–A9). With that width, every one of the 1024 base-register addresses can be swept, which covers every normal, DLL-reset and reserved pattern, including the top-bit case of R10. A mixed phase then drives pseudo-random banks, addresses and idle cycles. These interleavings reach the ordering cases of R7 and R8: a DLL reset followed by extended, unused-bank, reserved and repeated DLL-reset loads.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_DLLRST = 2'd1,
    CLS_RSVD   = 2'd2
  } mr_class_t;

  localparam int OPF_W     = 7;
  localparam int BASE_BANK = 0;
  localparam int EXT_BANK  = 1;
endpackage

// File: rtl/mrs_classify.sv
module mrs_classify
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output mr_class_t         cls
);
  localparam int UP_W = ADDR_W - OPF_W;
  localparam logic [UP_W-1:0] DLL_PAT = UP_W'(2);

  logic [UP_W-1:0] upper;
  assign upper = addr[ADDR_W-1:OPF_W];

  always_comb begin
    if (upper == '0)          cls = CLS_NORMAL;
    else if (upper == DLL_PAT) cls = CLS_DLLRST;
    else                      cls = CLS_RSVD;
  end

  initial begin
    a_r10_width_ok: assert (ADDR_W >= 9);
  end
endmodule

// File: rtl/mrs_base_reg.sv
module mrs_base_reg
  import mrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  mr_class_t        cls,
  input  logic [OPF_W-1:0] low_bits,
  output logic [OPF_W-1:0] op_field,
  output logic             dll_rst_pulse,
  output logic             rsvd_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_field      <= '0;
      dll_rst_pulse <= 1'b0;
      rsvd_err      <= 1'b0;
    end else begin
      dll_rst_pulse <= hit && (cls == CLS_DLLRST);
      rsvd_err      <= hit && (cls == CLS_RSVD);
      if (hit && (cls != CLS_RSVD)) op_field <= low_bits;
    end
  end

  a_r4_rsvd_keeps_field: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cls == CLS_RSVD) |=> $stable(op_field));
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dll_rst_pulse, rsvd_err}));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(op_field) && !dll_rst_pulse && !rsvd_err));
endmodule

// File: rtl/mrs_ext_reg.sv
module mrs_ext_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [1:0] ctl_bits,
  output logic       dll_enabled,
  output logic       drive_reduced
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_enabled   <= 1'b1;
      drive_reduced <= 1'b0;
    end else if (hit) begin
      dll_enabled   <= ~ctl_bits[0];
      drive_reduced <= ctl_bits[1];
    end
  end

  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(dll_enabled) && $stable(drive_reduced)));
endmodule

// File: rtl/mrs_seq_monitor.sv
module mrs_seq_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic any_load,
  input  logic normal_load,
  input  logic dllrst_load,
  output logic seq_warn
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      seq_warn <= 1'b0;
    end else if (normal_load) begin
      pending  <= 1'b0;
      seq_warn <= 1'b0;
    end else if (any_load) begin
      if (pending) seq_warn <= 1'b1;
      if (dllrst_load) pending <= 1'b1;
    end
  end

  a_r8_normal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    normal_load |=> !seq_warn);
  a_r8_no_warn_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !seq_warn) |=> !seq_warn);
  a_r7_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_warn && !normal_load) |=> seq_warn);
endmodule

// File: rtl/mode_cmd_decoder.sv
module mode_cmd_decoder
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [OPF_W-1:0]  op_field,
  output logic              dll_enabled,
  output logic              drive_reduced,
  output logic              dll_rst_pulse,
  output logic              rsvd_err,
  output logic              seq_warn
);
  mr_class_t cls;
  logic base_hit, ext_hit;

  assign base_hit = cmd_load && (cmd_bank == BANK_W'(BASE_BANK));
  assign ext_hit  = cmd_load && (cmd_bank == BANK_W'(EXT_BANK));

  mrs_classify #(.ADDR_W(ADDR_W)) u_cls (
    .addr (cmd_addr),
    .cls  (cls)
  );

  mrs_base_reg u_base (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (base_hit),
    .cls           (cls),
    .low_bits      (cmd_addr[OPF_W-1:0]),
    .op_field      (op_field),
    .dll_rst_pulse (dll_rst_pulse),
    .rsvd_err      (rsvd_err)
  );

  mrs_ext_reg u_ext (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (ext_hit),
    .ctl_bits      (cmd_addr[1:0]),
    .dll_enabled   (dll_enabled),
    .drive_reduced (drive_reduced)
  );

  mrs_seq_monitor u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_load    (cmd_load),
    .normal_load (base_hit && cls == CLS_NORMAL),
    .dllrst_load (base_hit && cls == CLS_DLLRST),
    .seq_warn    (seq_warn)
  );

  a_r3_pulse_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst_pulse |-> $past(base_hit));
  a_r5_ext_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> !rsvd_err);
endmodule

// File: tb/sim_mode_cmd_decoder.sv
module sim_mode_cmd_decoder;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 1'b0;
  logic [1:0] cmd_bank = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [6:0] op_field;
  logic dll_enabled, drive_reduced, dll_rst_pulse, rsvd_err, seq_warn;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int e_field, e_dll, e_drv, e_pend, e_warn;

  always #5 clk = ~clk;

  mode_cmd_decoder #(.ADDR_W(AW), .BANK_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .op_field(op_field), .dll_enabled(dll_enabled),
    .drive_reduced(drive_reduced), .dll_rst_pulse(dll_rst_pulse),
    .rsvd_err(rsvd_err), .seq_warn(seq_warn)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit ld, input int bank, input int addr);
    int up;
    bit is_norm, is_dll, is_rsv;
    string tag;
    @(negedge clk);
    cmd_load = ld; cmd_bank = 2'(bank); cmd_addr = AW'(addr);
    @(posedge clk);
    #1;
    up = addr >> 7;
    is_norm = ld && bank == 0 && up == 0;
    is_dll  = ld && bank == 0 && up == 2;
    is_rsv  = ld && bank == 0 && up != 0 && up != 2;
    if (is_norm || is_dll) e_field = addr & 7'h7f;
    if (ld && bank == 1) begin
      e_dll = (addr & 1) ? 0 : 1;
      e_drv = (addr >> 1) & 1;
    end
    if (is_norm) begin
      e_pend = 0; e_warn = 0;
    end else if (ld) begin
      if (e_pend != 0) e_warn = 1;
      if (is_dll) e_pend = 1;
    end
    tag = !ld ? "R9" : (bank >= 2) ? "R6" : (bank == 1) ? "R5" :
          is_norm ? "R2" : is_dll ? "R3" : (up == 4) ? "R10" : "R4";
    check({tag, " op_field"}, op_field, e_field);
    check({tag, " dll_rst_pulse"}, dll_rst_pulse, is_dll);
    check({tag, " rsvd_err"}, rsvd_err, is_rsv);
    check({tag, " dll_enabled"}, dll_enabled, e_dll);
    check({tag, " drive_reduced"}, drive_reduced, e_drv);
    check((e_warn != 0) ? "R7 seq_warn" : "R8 seq_warn", seq_warn, e_warn);
  endtask

  initial begin
    logic [15:0] lfsr;
    e_field = 0; e_dll = 1; e_drv = 0; e_pend = 0; e_warn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 op_field", op_field, 0);
    check("R1 dll_enabled", dll_enabled, 1);
    check("R1 drive_reduced", drive_reduced, 0);
    check("R1 dll_rst_pulse", dll_rst_pulse, 0);
    check("R1 rsvd_err", rsvd_err, 0);
    check("R1 seq_warn", seq_warn, 0);

    // exhaustive sweep of base-register addresses (R2, R3, R4, R10)
    for (int a = 0; a < (1 << AW); a++) begin
      step(1'b1, 0, a);
      if ((a % 5) == 0) step(1'b0, 0, a ^ 3);
    end
    // extended register, all low patterns (R5)
    for (int a = 0; a < 16; a++) step(1'b1, 1, a * 37);
    // directed ordering cases (R7, R8)
    step(1'b1, 0, 'h100 | 5); step(1'b1, 1, 2); step(1'b1, 0, 9);
    step(1'b1, 0, 'h100 | 6); step(1'b1, 3, 0); step(1'b0, 0, 0); step(1'b1, 0, 1);
    step(1'b1, 0, 'h100); step(1'b1, 0, 'h100); step(1'b1, 0, 'h300); step(1'b1, 0, 0);
    step(1'b1, 2, 'h3ff); step(1'b1, 0, 'h200 | 4);
    // mixed pseudo-random phase (R6, R7, R8, R9)
    lfsr = 16'hace1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15:14] != 2'b00, int'(lfsr[1:0]),
           (lfsr[5:4] == 2'b00) ? int'({3'b010, lfsr[12:6]}) : int'(lfsr[13:4]));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule